// File: doc/BRIEF.md
# Completion interrupt coalescer

This block moderates the interrupt traffic of a descriptor-driven DMA engine. The engine sends a one-cycle pulse on `done_i` each time it retires a descriptor. Rather than interrupting once per pulse, the coalescer counts the pending completions and measures how long the oldest of them has waited. It sets a sticky completion status bit once either measure passes a programmed limit. Elapsed time is counted in ticks of a prescaler. Each tick lasts `TICK_CYCLES` clock cycles, which at the default of 2500 cycles is 20 microseconds at 125 MHz.

Software reaches the block through a small 32-bit register port with a combinational read path. The port holds three registers: a configuration register with a coalescing enable and the two limits, a status register, and an interrupt enable register. The interrupt line is active while the status bit and the enable bit are both set, so software can mask it during service by clearing the enable. Writing 1 to the status bit acknowledges the interrupt and restarts the accumulation. When coalescing is switched off, every completion sets the status bit straight away.

Top module: `coal_irq`

## Requirements
- R1: After reset the configuration register reads 0x0014_1401 (coalescing on, count limit 20, time limit 20), and status, enable and `irq_o` are all 0.
- R2: The configuration register is at offset 0x0. Bit 0 is the coalescing enable, bits [14:8] the count limit and bits [22:16] the time limit, and every other bit reads 0.
- R3: The interrupt enable is bit 0 at offset 0x8 and is readable and writable. The status bit reads as bit 0 at offset 0x4.
- R4: `irq_o` is 1 exactly when both the status bit and the enable bit are 1.
- R5: With coalescing on, the status bit is set by the clock edge on which the number of pending completions first exceeds the count limit, that is on the (limit+1)-th completion.
- R6: With coalescing on, elapsed time starts with the first pending completion and advances one unit every `TICK_CYCLES` cycles. The status bit is set on the edge `TICK_CYCLES*(limit+1)` cycles after that completion's edge, and later completions do not restart the time.
- R7: Writing a value with bit 0 set to offset 0x4 clears the status bit, the pending count and the elapsed time. Writing 0 to that bit has no effect.
- R8: A completion in the same cycle as an acknowledge is counted as the first new pending completion.
- R9: With coalescing off (configuration bit 0 = 0), each completion sets the status bit on its own clock edge.
- R10: Once set, the status bit stays set until it is acknowledged.
- R11: Writes to unmapped offsets (for example 0xC) change no register, and writes to the status register never set the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| done_i | input | 1 | One-cycle pulse per finished descriptor |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register byte offset |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i`, combinational |
| irq_o | output | 1 | Completion interrupt |

## Verification
The bench builds the block with `TICK_CYCLES` = 4. At that value one time unit is four cycles, so the bench can sweep every time limit from 0 to 7 and check the exact firing edge of each, one cycle early and on time, within a few hundred cycles. It also sweeps every count limit from 0 to 7. During the count sweep the time limit is held at 127, so the two triggers are tested apart. A further set of sequences exercises acknowledge collisions, bypass mode, masking and register decoding.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int unsigned REG_AW = 4;
  localparam int unsigned REG_DW = 32;
  localparam int unsigned LIM_W  = 7;

  localparam logic [REG_AW-1:0] OFF_CFG  = 4'h0;
  localparam logic [REG_AW-1:0] OFF_STAT = 4'h4;
  localparam logic [REG_AW-1:0] OFF_EN   = 4'h8;

  localparam int unsigned CFG_EN_BIT   = 0;
  localparam int unsigned CFG_CNT_LSB  = 8;
  localparam int unsigned CFG_TIME_LSB = 16;
  localparam int unsigned STAT_BIT     = 0;
  localparam int unsigned EN_BIT       = 0;

  typedef struct packed {
    logic             coal_en;
    logic [LIM_W-1:0] cnt_lim;
    logic [LIM_W-1:0] time_lim;
  } cfg_t;

  localparam cfg_t CFG_RST = '{coal_en: 1'b1, cnt_lim: 7'd20, time_lim: 7'd20};
endpackage

// File: rtl/coal_regs.sv
module coal_regs
  import coal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic              stat_i,
  output cfg_t              cfg_o,
  output logic              en_o,
  output logic              ack_o,
  output logic [REG_DW-1:0] rdata_o
);
  cfg_t cfg_q;
  logic en_q;
  logic unused_wbits;

  assign unused_wbits = ^wdata_i;
  assign ack_o = we_i && (addr_i == OFF_STAT) && wdata_i[STAT_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
      en_q  <= 1'b0;
    end else if (we_i) begin
      if (addr_i == OFF_CFG) begin
        cfg_q.coal_en  <= wdata_i[CFG_EN_BIT];
        cfg_q.cnt_lim  <= wdata_i[CFG_CNT_LSB +: LIM_W];
        cfg_q.time_lim <= wdata_i[CFG_TIME_LSB +: LIM_W];
      end
      if (addr_i == OFF_EN) en_q <= wdata_i[EN_BIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_CFG: begin
        rdata_o[CFG_EN_BIT]             = cfg_q.coal_en;
        rdata_o[CFG_CNT_LSB +: LIM_W]   = cfg_q.cnt_lim;
        rdata_o[CFG_TIME_LSB +: LIM_W]  = cfg_q.time_lim;
      end
      OFF_STAT: rdata_o[STAT_BIT] = stat_i;
      OFF_EN:   rdata_o[EN_BIT]   = en_q;
      default:  rdata_o = '0;
    endcase
  end

  assign cfg_o = cfg_q;
  assign en_o  = en_q;
endmodule

// File: rtl/coal_tick.sv
module coal_tick #(
  parameter int unsigned TICK_CYCLES = 2500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == LAST);
  assign tick_o = run_i && !clr_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || !run_i)    cnt_q <= '0;
    else if (wrap)               cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/coal_engine.sv
module coal_engine
  import coal_pkg::*;
#(
  parameter int unsigned CW = LIM_W + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic          ack_i,
  input  logic          tick_i,
  input  cfg_t          cfg_i,
  output logic [CW-1:0] pend_o,
  output logic          fire_o
);
  logic [CW-1:0] pend_q, pend_base, pend_d;
  logic [CW-1:0] time_q, time_base, time_d;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  always_comb begin
    pend_base = ack_i ? '0 : pend_q;
    pend_d    = done_i ? sat_inc(pend_base) : pend_base;
    time_base = ack_i ? '0 : time_q;
    time_d    = (tick_i && !ack_i) ? sat_inc(time_base) : time_base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      time_q <= '0;
    end else begin
      pend_q <= pend_d;
      time_q <= time_d;
    end
  end

  // threshold test uses the post-update counts so the status lands on the crossing edge
  always_comb begin
    if (cfg_i.coal_en)
      fire_o = (pend_d > {1'b0, cfg_i.cnt_lim}) || (time_d > {1'b0, cfg_i.time_lim});
    else
      fire_o = done_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/coal_irq.sv
module coal_irq
  import coal_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 2500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned CW = LIM_W + 1;

  cfg_t          cfg;
  logic          en_q, ack, tick, fire, stat_q;
  logic [CW-1:0] pend_q;

  coal_regs u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .stat_i(stat_q), .cfg_o(cfg), .en_o(en_q), .ack_o(ack), .rdata_o
  );

  coal_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk_i, .rst_ni, .run_i(pend_q != '0), .clr_i(ack), .tick_o(tick)
  );

  coal_engine #(.CW(CW)) u_eng (
    .clk_i, .rst_ni, .done_i, .ack_i(ack), .tick_i(tick), .cfg_i(cfg),
    .pend_o(pend_q), .fire_o(fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= 1'b0;
    else         stat_q <= (stat_q && !ack) || fire;
  end

  assign irq_o = stat_q && en_q;
endmodule

// File: rtl/coal_irq_chk.sv
module coal_irq_chk
  import coal_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_i,
  input logic              we_i,
  input logic [REG_AW-1:0] addr_i,
  input logic [REG_DW-1:0] wdata_i,
  input logic              irq_o,
  input logic              stat_q,
  input logic              en_q,
  input logic              coal_en,
  input logic [LIM_W:0]    pend_q
);
  logic ack_w;
  assign ack_w = we_i && (addr_i == OFF_STAT) && wdata_i[STAT_BIT];

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q && !ack_w) |=> stat_q); // R10
  AST_FALL_NEEDS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stat_q) |-> $past(ack_w)); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_w && !done_i) |=> (pend_q == '0)); // R7
  AST_ACK_DONE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_w && done_i) |=> (pend_q == 1)); // R8
  AST_BYPASS_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!coal_en && done_i) |=> stat_q); // R9
  AST_MASK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !irq_o); // R4
endmodule

bind coal_irq coal_irq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .irq_o(irq_o), .stat_q(stat_q),
  .en_q(en_q), .coal_en(cfg.coal_en), .pend_q(pend_q)
);

// File: tb/coal_irq_test.sv
`timescale 1ns/1ps
module coal_irq_test;
  localparam int TICK = 4;
  logic clk_i = 1'b0, rst_ni = 1'b0, done_i = 1'b0, we_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic irq_o;
  int checks = 0, errors = 0, cyc = 0;

  coal_irq #(.TICK_CYCLES(TICK)) uut (.*);

  always #4 clk_i = ~clk_i;

  initial forever begin
    @(posedge clk_i);
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc1(input logic we, input logic [3:0] a, input logic [31:0] d, input logic dn);
    we_i = we; addr_i = a; wdata_i = d; done_i = dn;
    @(negedge clk_i);
    we_i = 1'b0; done_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  function automatic logic [31:0] cfgw(input logic en, input int cnt, input int tim);
    return {9'b0, 7'(tim), 1'b0, 7'(cnt), 7'b0, en};
  endfunction

  task automatic setup(input logic en, input int cnt, input int tim);
    cyc1(1, 4'h0, cfgw(en, cnt, tim), 0);
    cyc1(1, 4'h8, 32'h1, 0);
    cyc1(1, 4'h4, 32'h1, 0);
  endtask

  initial begin
    logic [31:0] d;
    #20; @(negedge clk_i); rst_ni = 1'b1;
    // R1 reset state
    rd(4'h0, d); chk("R1 cfg", d, 32'h0014_1401);
    rd(4'h4, d); chk("R1 status", d, 0);
    rd(4'h8, d); chk("R1 enable", d, 0);
    chk("R1 irq", irq_o, 0);
    // R2 field layout
    cyc1(1, 4'h0, 32'hFFFF_FFFF, 0);
    rd(4'h0, d); chk("R2 all ones", d, 32'h007F_7F01);
    cyc1(1, 4'h0, cfgw(0, 5, 9), 0);
    rd(4'h0, d); chk("R2 fields", d, 32'h0009_0500);
    // R3 enable
    cyc1(1, 4'h8, 32'hFFFF_FFFF, 0);
    rd(4'h8, d); chk("R3 enable set", d, 1);
    cyc1(1, 4'h8, 32'hFFFF_FFFE, 0);
    rd(4'h8, d); chk("R3 enable clr", d, 0);
    // R11 unmapped write and status write cannot set
    cyc1(1, 4'hC, 32'hFFFF_FFFF, 0);
    rd(4'h0, d); chk("R11 cfg kept", d, 32'h0009_0500);
    rd(4'h8, d); chk("R11 en kept", d, 0);
    cyc1(1, 4'h4, 32'hFFFF_FFFF, 0);
    rd(4'h4, d); chk("R11 status not set", d, 0);

    // R5 count sweep
    for (int lim = 0; lim < 8; lim++) begin
      setup(1, lim, 127);
      for (int k = 1; k <= lim + 1; k++) begin
        cyc1(0, 4'h0, 0, 1);
        rd(4'h4, d); chk($sformatf("R5 lim=%0d k=%0d", lim, k), d, (k > lim) ? 1 : 0);
        chk("R5 R4 irq", irq_o, (k > lim) ? 1 : 0);
      end
    end

    // R6 time sweep
    for (int lim = 0; lim < 8; lim++) begin
      setup(1, 127, lim);
      cyc1(0, 4'h0, 0, 1);
      for (int i = 1; i < TICK * (lim + 1); i++) cyc1(0, 4'h0, 0, i == 2);
      rd(4'h4, d); chk($sformatf("R6 early lim=%0d", lim), d, 0);
      cyc1(0, 4'h0, 0, 0);
      rd(4'h4, d); chk($sformatf("R6 ontime lim=%0d", lim), d, 1);
    end

    // R10 sticky, R7 zero write ignored
    for (int i = 0; i < 20; i++) cyc1(0, 4'h0, 0, 0);
    rd(4'h4, d); chk("R10 sticky", d, 1);
    cyc1(1, 4'h4, 32'h0, 0);
    rd(4'h4, d); chk("R7 zero write", d, 1);

    // R4 masking
    cyc1(1, 4'h8, 32'h0, 0);
    chk("R4 masked", irq_o, 0);
    cyc1(1, 4'h8, 32'h1, 0);
    chk("R4 unmasked", irq_o, 1);

    // R7 ack clears count
    setup(1, 1, 127);
    cyc1(0, 4'h0, 0, 1);
    rd(4'h4, d); chk("R7 one pending", d, 0);
    cyc1(1, 4'h4, 32'h1, 0);
    cyc1(0, 4'h0, 0, 1);
    rd(4'h4, d); chk("R7 count cleared", d, 0);
    // R8 completion with ack counted
    cyc1(1, 4'h4, 32'h1, 1);
    rd(4'h4, d); chk("R8 ack+done", d, 0);
    cyc1(0, 4'h0, 0, 1);
    rd(4'h4, d); chk("R8 second fires", d, 1);
    // R7 ack clears time
    setup(1, 127, 1);
    cyc1(0, 4'h0, 0, 1);
    for (int i = 0; i < 5; i++) cyc1(0, 4'h0, 0, 0);
    cyc1(1, 4'h4, 32'h1, 0);
    cyc1(0, 4'h0, 0, 1);
    for (int i = 1; i < 2 * TICK; i++) cyc1(0, 4'h0, 0, 0);
    rd(4'h4, d); chk("R7 time cleared", d, 0);
    cyc1(0, 4'h0, 0, 0);
    rd(4'h4, d); chk("R7 time restart fire", d, 1);

    // R9 bypass
    setup(0, 127, 127);
    rd(4'h4, d); chk("R9 idle", d, 0);
    cyc1(0, 4'h0, 0, 1);
    rd(4'h4, d); chk("R9 immediate", d, 1);
    cyc1(1, 4'h4, 32'h1, 1);
    rd(4'h4, d); chk("R9 ack+done", d, 1);
    cyc1(1, 4'h4, 32'h1, 0);
    rd(4'h4, d); chk("R9 acked", d, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule